// File: doc/BRIEF.md
# Ethernet Link Mode Auto-Negotiation Resolver

This block is the decision engine that chooses the operating mode of a twisted-pair Ethernet port. It watches the local ability vector, the partner's ability page delivered by an external pulse decoder, and three line detectors: page received, scrambled idle seen, and plain link pulses seen. From these it settles on one speed and duplex combination, raises a link-up flag and records the outcome in a status word. The waveform timing of the pulse bursts is handled elsewhere. The next-page message exchange is only a stub here: when a configuration bit allows it, the block waits for an external done pulse before it resolves.

Negotiation restarts on a hard reset, on a soft reset, on a rising edge of the enable control, on a write of the restart bit, and on a link-fail event while negotiation is enabled. When negotiation is disabled, the port runs in a forced mode that software selects, and link-fail events leave that mode alone. A legacy partner that sends no ability pages is still served by parallel detection. Scrambled idle gives 100 Mb/s half duplex, and plain link pulses give 10 Mb/s half duplex.

Top module: `an_resolver`

## Requirements
- R1: After hard reset the block is negotiating (`an_busy`=1), with `link_up`=0, `restart_bit`=0 and `an_status`=0.
- R2: On a received page, the chosen mode is the highest common mode of `local_abil & partner_abil` in the order 100 full (bit 4), 100 half (bit 2), 10 full (bit 1), 10 half (bit 0). Status bits [2:0] then hold the mode code (1=10 half, 2=10 full, 3=100 half, 4=100 full) and bit [3] is set to mark completion.
- R3: Ability bit 3 (the four-pair 100 Mb/s mode) is never chosen. If it is the only common bit, the result is a failure.
- R4: With no usable common mode, negotiation fails: status bit [5] and bit [3] are set, the mode code is 0, `link_up`=0 and the block stays idle until the next start event.
- R5: With no page but with `idle_seen`, the link comes up at 100 half duplex and status bit [4] (parallel detect) is set. If the local side lacks both 100 Mb/s abilities, the result is a failure that also has bit [4] set.
- R6: With no page and no idle but with `nlp_seen`, the link comes up at 10 half duplex with status bit [4] set.
- R7: A write of the restart bit while enabled starts negotiation. `restart_bit` then reads 1 for exactly the following cycle and clears by itself.
- R8: A link-fail event while enabled, a soft reset, and a rising edge of `an_enable` each start negotiation. A soft reset also clears `an_status` to 0.
- R9: With `an_enable`=0 the outputs follow `forced_mode` (same codes as R2), and `link_fail` changes nothing.
- R10: When `np_enable`=0, a partner's next-page request is ignored and the block resolves at once. When `np_enable`=1 and the partner requests next pages, the block stays busy until an `np_done` pulse arrives and then resolves.
- R11: A page reported with reversed pulse polarity (`flp_neg`) resolves exactly like one with normal polarity (`flp_pos`).
- R12: `an_status` changes only when negotiation completes or on a reset. It keeps its last value while a new negotiation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| an_enable | input | 1 | Negotiation enable control bit |
| restart_wr | input | 1 | Write of 1 to the restart bit (one-cycle pulse) |
| soft_reset | input | 1 | Soft reset pulse |
| link_fail | input | 1 | Link-fail event pulse |
| np_enable | input | 1 | Allows the next-page exchange stub |
| local_abil | input | 5 | Local ability vector (bit encoding in R2/R3) |
| partner_abil | input | 5 | Partner ability vector, valid with a page pulse |
| partner_np | input | 1 | Partner requests next pages, valid with a page pulse |
| flp_pos | input | 1 | Page received, normal polarity |
| flp_neg | input | 1 | Page received, reversed polarity |
| idle_seen | input | 1 | Scrambled idle detected |
| nlp_seen | input | 1 | Normal link pulses detected |
| np_done | input | 1 | Next-page exchange finished |
| forced_mode | input | 3 | Mode used while negotiation is disabled |
| link_up | output | 1 | Link established |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | output | 1 | 1 = full duplex |
| an_busy | output | 1 | Negotiation in progress |
| restart_bit | output | 1 | Self-clearing restart bit readback |
| an_status | output | 8 | Summary status: [2:0] mode, [3] complete, [4] parallel detect, [5] fail |

## Verification
The hardest states to reach are those where a completed negotiation is followed by a new one, because R12 requires the old status to persist while the block is busy again. It is also hard to reach the next-page wait, where a page has arrived but nothing may resolve yet. The stimulus chains scenarios without a hard reset between them and moves from one to the next with restart writes, link-fail pulses, soft resets and enable toggles. This way every start event fires from a state that already holds a result. A behavioural model in the bench is compared against all outputs on every cycle of that chain.

// File: rtl/an_pkg.sv
package an_pkg;

    localparam int ABIL_W    = 5;
    localparam int STAT_W    = 8;
    localparam int IDX_10HD  = 0;
    localparam int IDX_10FD  = 1;
    localparam int IDX_100HD = 2;
    localparam int IDX_T4    = 3;
    localparam int IDX_100FD = 4;
    localparam logic [ABIL_W-1:0] USABLE_MASK = ~(ABIL_W'(1) << IDX_T4);

    typedef enum logic [2:0] {
        MODE_NONE  = 3'd0,
        MODE_10HD  = 3'd1,
        MODE_10FD  = 3'd2,
        MODE_100HD = 3'd3,
        MODE_100FD = 3'd4
    } link_mode_e;

    typedef enum logic [2:0] {
        ST_NEG    = 3'd0,
        ST_NPX    = 3'd1,
        ST_DONE   = 3'd2,
        ST_FAIL   = 3'd3,
        ST_FORCED = 3'd4
    } neg_state_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       fail;
        logic       pd;
        logic       complete;
        link_mode_e mode;
    } an_status_t;

    function automatic link_mode_e mode_of_bit(input int idx);
        case (idx)
            IDX_10HD:  return MODE_10HD;
            IDX_10FD:  return MODE_10FD;
            IDX_100HD: return MODE_100HD;
            IDX_100FD: return MODE_100FD;
            default:   return MODE_NONE;
        endcase
    endfunction

    function automatic int bit_of(input link_mode_e m);
        case (m)
            MODE_10HD:  return IDX_10HD;
            MODE_10FD:  return IDX_10FD;
            MODE_100HD: return IDX_100HD;
            MODE_100FD: return IDX_100FD;
            default:    return IDX_T4;
        endcase
    endfunction

    function automatic logic is_100(input link_mode_e m);
        return (m == MODE_100HD) || (m == MODE_100FD);
    endfunction

    function automatic logic is_full(input link_mode_e m);
        return (m == MODE_10FD) || (m == MODE_100FD);
    endfunction

    function automatic logic mode_ok(input link_mode_e m);
        return (m == MODE_10HD) || (m == MODE_10FD) || is_100(m);
    endfunction

endpackage

// File: rtl/an_hcd.sv
module an_hcd
    import an_pkg::*;
(
    input  logic [ABIL_W-1:0] common,
    output link_mode_e        best
);
    // Upward scan: a later (higher) usable bit overrides, which matches the priority order.
    always_comb begin
        best = MODE_NONE;
        for (int i = 0; i < ABIL_W; i++) begin
            if (common[i] && (mode_of_bit(i) != MODE_NONE)) best = mode_of_bit(i);
        end
    end

    always_comb begin
        if (!$isunknown(common)) begin
            if (best != MODE_NONE)
                a_r2_pick_in_common: assert (common[bit_of(best)]);
            if ((common & USABLE_MASK) == '0)
                a_r3_never_t4: assert (best == MODE_NONE);
        end
    end
endmodule

// File: rtl/an_trigger.sv
module an_trigger (
    input  logic clk,
    input  logic rst,
    input  logic an_enable,
    input  logic restart_wr,
    input  logic link_fail,
    input  logic soft_reset,
    output logic start,
    output logic restart_bit
);
    logic en_q;

    assign start = an_enable && (!en_q || restart_wr || link_fail);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b1;
            restart_bit <= 1'b0;
        end else begin
            en_q        <= an_enable;
            restart_bit <= an_enable && restart_wr && !soft_reset;
        end
    end

    a_r7_restart_self_clears: assert property (@(posedge clk) disable iff (rst)
        (restart_bit && !restart_wr) |=> !restart_bit);
endmodule

// File: rtl/an_seq.sv
module an_seq
    import an_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_reset,
    input  logic              an_enable,
    input  logic              start,
    input  logic              link_fail,
    input  logic              page_rx,
    input  logic              partner_np,
    input  logic              np_enable,
    input  logic              np_done,
    input  logic              idle_seen,
    input  logic              nlp_seen,
    input  logic [ABIL_W-1:0] local_abil,
    input  logic [ABIL_W-1:0] partner_abil,
    input  link_mode_e        best,
    output logic [ABIL_W-1:0] cmp_vec,
    output neg_state_e        st,
    output link_mode_e        mode_q,
    output an_status_t        status_q
);
    logic [ABIL_W-1:0] held_q;
    logic              fin, fin_pd, go_np;
    link_mode_e        fin_mode;
    logic              loc_100, loc_10;

    assign loc_100 = local_abil[IDX_100HD] | local_abil[IDX_100FD];
    assign loc_10  = local_abil[IDX_10HD]  | local_abil[IDX_10FD];

    always_comb cmp_vec = (st == ST_NPX) ? held_q : (local_abil & partner_abil);

    always_comb begin
        fin      = 1'b0;
        fin_pd   = 1'b0;
        go_np    = 1'b0;
        fin_mode = MODE_NONE;
        case (st)
            ST_NEG: begin
                if (page_rx) begin
                    if (np_enable && partner_np) go_np = 1'b1;
                    else begin
                        fin      = 1'b1;
                        fin_mode = best;
                    end
                end else if (idle_seen) begin
                    fin      = 1'b1;
                    fin_pd   = 1'b1;
                    fin_mode = loc_100 ? MODE_100HD : MODE_NONE;
                end else if (nlp_seen) begin
                    fin      = 1'b1;
                    fin_pd   = 1'b1;
                    fin_mode = loc_10 ? MODE_10HD : MODE_NONE;
                end
            end
            ST_NPX: begin
                if (np_done) begin
                    fin      = 1'b1;
                    fin_mode = best;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_NEG;
            mode_q   <= MODE_NONE;
            status_q <= '0;
            held_q   <= '0;
        end else if (soft_reset) begin
            st       <= an_enable ? ST_NEG : ST_FORCED;
            mode_q   <= MODE_NONE;
            status_q <= '0;
        end else if (!an_enable) begin
            st <= ST_FORCED;
        end else if (start) begin
            st <= ST_NEG;
        end else if (go_np) begin
            held_q <= cmp_vec;
            st     <= ST_NPX;
        end else if (fin) begin
            st       <= (fin_mode == MODE_NONE) ? ST_FAIL : ST_DONE;
            mode_q   <= fin_mode;
            status_q <= '{rsvd: 2'b00, fail: (fin_mode == MODE_NONE),
                          pd: fin_pd, complete: 1'b1, mode: fin_mode};
        end
    end

    a_r8_linkfail_restarts: assert property (@(posedge clk) disable iff (rst)
        (an_enable && link_fail && !soft_reset) |=> (st == ST_NEG));

    a_r9_disabled_forced: assert property (@(posedge clk) disable iff (rst)
        (!an_enable && !soft_reset) |=> (st == ST_FORCED));

    a_r12_status_on_completion: assert property (@(posedge clk) disable iff (rst)
        (status_q != $past(status_q)) |->
            ((st == ST_DONE) || (st == ST_FAIL) || $past(soft_reset)));
endmodule

// File: rtl/an_resolver.sv
module an_resolver
    import an_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              an_enable,
    input  logic              restart_wr,
    input  logic              soft_reset,
    input  logic              link_fail,
    input  logic              np_enable,
    input  logic [ABIL_W-1:0] local_abil,
    input  logic [ABIL_W-1:0] partner_abil,
    input  logic              partner_np,
    input  logic              flp_pos,
    input  logic              flp_neg,
    input  logic              idle_seen,
    input  logic              nlp_seen,
    input  logic              np_done,
    input  logic [2:0]        forced_mode,
    output logic              link_up,
    output logic              speed_100,
    output logic              full_duplex,
    output logic              an_busy,
    output logic              restart_bit,
    output logic [STAT_W-1:0] an_status
);
    logic              start;
    logic              page_rx;
    logic [ABIL_W-1:0] cmp_vec;
    link_mode_e        best, mode_q, cur_mode, forced_e;
    neg_state_e        st;
    an_status_t        status_q;

    assign page_rx  = flp_pos | flp_neg;
    assign forced_e = link_mode_e'(forced_mode);

    an_trigger u_trig (
        .clk         (clk),
        .rst         (rst),
        .an_enable   (an_enable),
        .restart_wr  (restart_wr),
        .link_fail   (link_fail),
        .soft_reset  (soft_reset),
        .start       (start),
        .restart_bit (restart_bit)
    );

    an_hcd u_hcd (
        .common (cmp_vec),
        .best   (best)
    );

    an_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .soft_reset   (soft_reset),
        .an_enable    (an_enable),
        .start        (start),
        .link_fail    (link_fail),
        .page_rx      (page_rx),
        .partner_np   (partner_np),
        .np_enable    (np_enable),
        .np_done      (np_done),
        .idle_seen    (idle_seen),
        .nlp_seen     (nlp_seen),
        .local_abil   (local_abil),
        .partner_abil (partner_abil),
        .best         (best),
        .cmp_vec      (cmp_vec),
        .st           (st),
        .mode_q       (mode_q),
        .status_q     (status_q)
    );

    always_comb begin
        case (st)
            ST_DONE:   cur_mode = mode_q;
            ST_FORCED: cur_mode = mode_ok(forced_e) ? forced_e : MODE_NONE;
            default:   cur_mode = MODE_NONE;
        endcase
    end

    assign link_up     = (cur_mode != MODE_NONE);
    assign speed_100   = is_100(cur_mode);
    assign full_duplex = is_full(cur_mode);
    assign an_busy     = (st == ST_NEG) || (st == ST_NPX);
    assign an_status   = status_q;

    a_r4_fail_no_link: assert property (@(posedge clk) disable iff (rst)
        an_status[5] |-> (an_status[2:0] == 3'd0));
endmodule

// File: tb/an_resolver_test.sv
`timescale 1ns/1ps
module an_resolver_test;
    logic clk = 0;
    logic rst, an_enable, restart_wr, soft_reset, link_fail, np_enable;
    logic [4:0] local_abil, partner_abil;
    logic partner_np, flp_pos, flp_neg, idle_seen, nlp_seen, np_done;
    logic [2:0] forced_mode;
    logic link_up, speed_100, full_duplex, an_busy, restart_bit;
    logic [7:0] an_status;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit cmp_on = 0;

    always #4 clk = ~clk;

    an_resolver uut (.*);

    // behavioural reference: 0 negotiating, 1 next-page wait, 2 up, 3 failed, 4 forced
    int mst, mmode, mstat, mheld;
    bit mrs, menq;

    function automatic int pick(input int c);
        if (c & 16) return 4;
        if (c & 4)  return 3;
        if (c & 2)  return 2;
        if (c & 1)  return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mst = 0; mmode = 0; mstat = 0; mheld = 0; mrs = 0; menq = 1;
        end else begin
            automatic bit st_ev = an_enable && (!menq || restart_wr || link_fail);
            automatic bit nrs = an_enable && restart_wr && !soft_reset;
            automatic int res = -1;
            automatic int pd = 0;
            if (soft_reset) begin
                mst = an_enable ? 0 : 4; mmode = 0; mstat = 0;
            end else if (!an_enable) mst = 4;
            else if (st_ev) mst = 0;
            else if (mst == 0) begin
                if (flp_pos || flp_neg) begin
                    if (np_enable && partner_np) begin
                        mheld = local_abil & partner_abil; mst = 1;
                    end else res = pick(local_abil & partner_abil);
                end else if (idle_seen) begin
                    pd = 1; res = (local_abil & 5'b10100) ? 3 : 0;
                end else if (nlp_seen) begin
                    pd = 1; res = (local_abil & 5'b00011) ? 1 : 0;
                end
            end else if (mst == 1 && np_done) res = pick(mheld);
            if (res >= 0) begin
                mst   = (res == 0) ? 3 : 2;
                mmode = res;
                mstat = res + 8 + pd * 16 + ((res == 0) ? 32 : 0);
            end
            menq = an_enable; mrs = nrs;
        end
    end

    always begin
        @(negedge clk); #3;
        if (cmp_on) begin
            automatic int cur = (mst == 2) ? mmode :
                                (mst == 4 && forced_mode >= 1 && forced_mode <= 4) ? int'(forced_mode) : 0;
            automatic bit e_link = cur != 0;
            automatic bit e_spd = (cur == 3 || cur == 4);
            automatic bit e_fd = (cur == 2 || cur == 4);
            automatic bit e_busy = (mst <= 1);
            n_tests++;
            if (link_up !== e_link || speed_100 !== e_spd || full_duplex !== e_fd ||
                an_busy !== e_busy || restart_bit !== mrs || an_status !== 8'(mstat)) begin
                n_fail++;
                $display("FAIL %s model: act link=%b spd=%b fd=%b busy=%b rs=%b st=%h exp link=%b spd=%b fd=%b busy=%b rs=%b st=%h",
                         cur_req, link_up, speed_100, full_duplex, an_busy, restart_bit, an_status,
                         e_link, e_spd, e_fd, e_busy, mrs, 8'(mstat));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic page(input bit neg, input logic [4:0] p, input bit np);
        @(negedge clk);
        partner_abil = p; partner_np = np;
        if (neg) flp_neg = 1; else flp_pos = 1;
        @(negedge clk);
        flp_pos = 0; flp_neg = 0; partner_np = 0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    initial begin
        #(20000 * 8);
        n_fail++;
        $display("FAIL watchdog: act running exp finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; an_enable = 1; restart_wr = 0; soft_reset = 0; link_fail = 0;
        np_enable = 0; local_abil = 5'b10111; partner_abil = 0; partner_np = 0;
        flp_pos = 0; flp_neg = 0; idle_seen = 0; nlp_seen = 0; np_done = 0; forced_mode = 0;
        cyc(3);
        rst = 0;
        cmp_on = 1;
        cyc(1);
        // R1 reset state
        chk("R1 busy", an_busy, 1); chk("R1 link", link_up, 0);
        chk("R1 status", an_status, 0); chk("R1 restart", restart_bit, 0);

        // R2 common 00111 -> 100 half
        cur_req = "R2";
        page(0, 5'b00111, 0);
        chk("R2 status 100HD", an_status, 8'h0B); chk("R2 speed", speed_100, 1);
        chk("R2 duplex", full_duplex, 0);

        // R7 restart bit one cycle, R12 status held while busy
        cur_req = "R7";
        pulse(restart_wr);
        chk("R7 restart set", restart_bit, 1);
        cyc(1);
        chk("R7 restart cleared", restart_bit, 0); chk("R7 busy", an_busy, 1);
        chk("R12 status held", an_status, 8'h0B);
        cur_req = "R2";
        page(0, 5'b11111, 0);
        chk("R2 status 100FD", an_status, 8'h0C);

        // R3 T4 skipped
        cur_req = "R3";
        local_abil = 5'b11111;
        pulse(restart_wr);
        page(0, 5'b01011, 0);
        chk("R3 skip T4 -> 10FD", an_status, 8'h0A);

        // R4 no common mode
        cur_req = "R4";
        local_abil = 5'b00011;
        pulse(restart_wr);
        page(0, 5'b00100, 0);
        chk("R4 fail status", an_status, 8'h28); chk("R4 link", link_up, 0);
        chk("R4 idle", an_busy, 0);
        cyc(3);
        chk("R4 stays failed", an_status, 8'h28);

        // R3 T4 only common
        cur_req = "R3";
        local_abil = 5'b11111;
        pulse(restart_wr);
        page(0, 5'b01000, 0);
        chk("R3 T4 only fails", an_status, 8'h28);

        // R11 reversed polarity
        cur_req = "R11";
        pulse(restart_wr);
        page(1, 5'b00011, 0);
        chk("R11 reversed page", an_status, 8'h0A); chk("R11 link", link_up, 1);

        // R8 link fail + R5 idle
        cur_req = "R8";
        pulse(link_fail);
        chk("R8 link fail restarts", an_busy, 1);
        cur_req = "R5";
        pulse(idle_seen);
        chk("R5 idle pd", an_status, 8'h1B); chk("R5 speed", speed_100, 1);

        // R6 nlp
        cur_req = "R6";
        pulse(link_fail);
        pulse(nlp_seen);
        chk("R6 nlp pd", an_status, 8'h19); chk("R6 speed", speed_100, 0);

        // R5 idle without local 100 ability
        cur_req = "R5";
        local_abil = 5'b00011;
        pulse(restart_wr);
        pulse(idle_seen);
        chk("R5 idle fail", an_status, 8'h38);

        // R10 next page
        cur_req = "R10";
        local_abil = 5'b11111;
        pulse(restart_wr);
        page(0, 5'b10000, 1);
        chk("R10 np ignored", an_status, 8'h0C);
        np_enable = 1;
        pulse(restart_wr);
        page(0, 5'b00001, 1);
        chk("R10 np wait busy", an_busy, 1); chk("R10 np wait status", an_status, 8'h0C);
        cyc(2);
        pulse(np_done);
        chk("R10 np done", an_status, 8'h09);
        np_enable = 0;

        // R8 soft reset
        cur_req = "R8";
        pulse(soft_reset);
        chk("R8 soft clears", an_status, 0); chk("R8 soft busy", an_busy, 1);
        page(0, 5'b00010, 0);
        chk("R8 after soft", an_status, 8'h0A);

        // R9 forced
        cur_req = "R9";
        forced_mode = 3'd4; an_enable = 0;
        cyc(2);
        chk("R9 forced link", link_up, 1); chk("R9 forced fd", full_duplex, 1);
        pulse(link_fail);
        cyc(1);
        chk("R9 link fail ignored", {link_up, speed_100, full_duplex, an_busy}, 4'b1110);
        forced_mode = 3'd1;
        cyc(1);
        chk("R9 forced 10HD", {speed_100, full_duplex}, 2'b00);
        chk("R12 forced keeps status", an_status, 8'h0A);

        // R8 rising enable
        cur_req = "R8";
        an_enable = 1;
        cyc(1);
        chk("R8 enable rise", an_busy, 1); chk("R12 status kept", an_status, 8'h0A);
        page(0, 5'b10100, 0);
        chk("R8 renegotiated", an_status, 8'h0C);
        cyc(2);

        cmp_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule